// File: doc/BRIEF.md
# Streaming Rectified-Linear Activation Engine

This block applies a rectified-linear activation to a vector of signed 32-bit integers that sit in an on-chip source RAM. The result goes to a separate destination RAM. A layer sequencer launches a pass with a one-cycle start pulse. The engine then walks the vector from index 0 upward. For each element it drives a read address, waits one cycle for the synchronous RAM to return the word, and looks only at the sign bit. It then writes either the unchanged word or zero to the same index of the destination buffer, using a one-cycle write strobe.

Control is one enumerated state machine with four states. IDLE waits for start. WAIT presents the read address and lets read data settle. APPLY evaluates the sign bit and strobes the write. FINISH holds done. WAIT and APPLY together form the compute phase.

The transitions are:
- IDLE to WAIT on start, which clears the index.
- WAIT to APPLY, always.
- APPLY to WAIT when the element is not the last one, which advances the index.
- APPLY to FINISH on the last element.
- FINISH to WAIT on a new start, which clears the index again.

A start that arrives in WAIT or APPLY has no effect. The vector length is a parameter, and a pass over N elements takes 2N cycles.

Top module: `relu_stream_engine`

## Requirements
- R1: After reset, done_o is 0, wr_en_o is 0, and the engine is idle.
- R2: A one-cycle start_i pulse in IDLE begins a pass. The first read address is 0.
- R3: Each element takes exactly two cycles. Its read address is held for the cycle before its write. wr_en_o is high for exactly one cycle per element.
- R4: When bit 31 of a source word is 1, the written word is 0. Otherwise the word is written unchanged. This holds for 0, 32'h7FFF_FFFF, 32'h8000_0000 and 32'hFFFF_FFFF.
- R5: The write address equals the read address of the same element. Elements are written in ascending order, 0 to VEC_LEN-1, each exactly once per pass.
- R6: wr_en_o is 0 in IDLE and in FINISH.
- R7: done_o first reads 1 after the 2·VEC_LEN-th rising edge following the edge that captured start.
- R8: done_o stays at 1 until the next start. A start in FINISH clears done_o at the next edge and begins a new pass.
- R9: A start pulse during a pass is ignored. The pass keeps its timing, its order and its write count.
- R10: VEC_LEN is a parameter. The engine works at both 64 and 32 elements, and the address widths follow from VEC_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle launch pulse from the sequencer |
| rd_addr_o | output | ADDR_W | Source RAM read address |
| rd_data_i | input | DATA_W | Source RAM read data, valid one cycle after the address |
| wr_addr_o | output | ADDR_W | Destination RAM write address |
| wr_data_o | output | DATA_W | Activated word to write |
| wr_en_o | output | 1 | Destination RAM write strobe |
| done_o | output | 1 | Pass complete, held until the next start |

## Verification
A state machine stuck in, or skipping, WAIT or APPLY shows up within two cycles. The write strobe either goes missing or appears on two consecutive cycles. The pass length then also differs from 2·VEC_LEN. A wrong index register shows on the very next strobe: the write address repeats or jumps, or it differs from the read address held in the preceding cycle. The bench catches these by comparing the address of every strobe against a running count. A wrong sign test shows up only in the stored words. For that reason every destination word is compared with a clamp the bench computes itself, over patterns that include zero and both extreme values.

// File: rtl/relu_stream_pkg.sv
package relu_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_APPLY  = 2'd2,
        ST_FINISH = 2'd3
    } relu_state_e;

    function automatic int unsigned addr_width(input int unsigned len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/relu_seq_ctrl.sv
module relu_seq_ctrl
    import relu_stream_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        last_i,
    output relu_state_e state_o,
    output logic        idx_clr_o,
    output logic        idx_inc_o
);

    relu_state_e state_q;
    relu_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_WAIT;
            ST_WAIT:   state_d = ST_APPLY;
            ST_APPLY:  state_d = last_i ? ST_FINISH : ST_WAIT;
            ST_FINISH: if (start_i) state_d = ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        idx_clr_o = 1'b0;
        idx_inc_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   idx_clr_o = start_i;
            ST_WAIT:   ;
            ST_APPLY:  idx_inc_o = !last_i;
            ST_FINISH: idx_clr_o = start_i;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // R9
    busy_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT || state_q == ST_APPLY) |=> (state_q != ST_IDLE));

    // R3
    wait_then_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |=> (state_q == ST_APPLY));

    // R8
    finish_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && !start_i) |=> (state_q == ST_FINISH));

endmodule

// File: rtl/relu_index_ctr.sv
module relu_index_ctr #(
    parameter int unsigned LEN    = 64,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] idx_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(LEN - 1);

    logic [ADDR_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);

    // R5
    ascending_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (idx_q == $past(idx_q) + 1'b1));

    // R10
    index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);

endmodule

// File: rtl/relu_sign_clamp.sv
module relu_sign_clamp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] value_o
);

    always_comb begin
        value_o = value_i[DATA_W-1] ? '0 : value_i;
    end

endmodule

// File: rtl/relu_stream_engine.sv
module relu_stream_engine
    import relu_stream_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned VEC_LEN = 64,
    parameter int unsigned ADDR_W  = addr_width(VEC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_en_o,
    output logic              done_o
);

    relu_state_e       state;
    logic              idx_clr;
    logic              idx_inc;
    logic              idx_last;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] clamped;

    relu_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .last_i    (idx_last),
        .state_o   (state),
        .idx_clr_o (idx_clr),
        .idx_inc_o (idx_inc)
    );

    relu_index_ctr #(
        .LEN    (VEC_LEN),
        .ADDR_W (ADDR_W)
    ) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (idx_clr),
        .inc_i  (idx_inc),
        .idx_o  (idx),
        .last_o (idx_last)
    );

    relu_sign_clamp #(
        .DATA_W (DATA_W)
    ) u_clamp (
        .value_i (rd_data_i),
        .value_o (clamped)
    );

    // port outputs
    always_comb begin
        rd_addr_o = idx;
        wr_addr_o = idx;
        wr_data_o = clamped;
        wr_en_o   = (state == ST_APPLY);
        done_o    = (state == ST_FINISH);
    end

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R3
    read_held_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en_o) |-> (rd_addr_o == $past(rd_addr_o)));

    // R6
    no_write_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !done_o);

    // R4
    never_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !wr_data_o[DATA_W-1]);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R2
    launch_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !done_o && $past(done_o || !wr_en_o) && start_i && state == ST_IDLE)
            |=> (rd_addr_o == '0));

endmodule

// File: tb/relu_stream_engine_tb.sv
module relu_ram_model #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          wr_en,
    output int            wr_count,
    output int            order_err
);
    logic [31:0] src [DEPTH];
    logic [31:0] dst [DEPTH];
    logic [AW-1:0] prev_rd;

    initial begin
        rd_data   = '0;
        wr_count  = 0;
        order_err = 0;
        prev_rd   = '0;
    end

    always @(posedge clk) begin
        rd_data <= src[rd_addr];
        prev_rd <= rd_addr;
        if (clr) begin
            wr_count  <= 0;
            order_err <= 0;
            for (int i = 0; i < DEPTH; i++) dst[i] <= 32'hA5A5_5A5A;
        end else if (wr_en) begin
            dst[wr_addr] <= wr_data;
            wr_count     <= wr_count + 1;
            if (wr_count >= DEPTH || int'(wr_addr) != wr_count ||
                prev_rd != wr_addr || rd_addr != wr_addr)
                order_err <= order_err + 1;
        end
    end
endmodule

module relu_stream_engine_tb;
    localparam int N64 = 64;
    localparam int N32 = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start64 = 1'b0;
    logic start32 = 1'b0;
    logic clr = 1'b0;

    logic [5:0]  rd_addr64, wr_addr64;
    logic [31:0] rd_data64, wr_data64;
    logic        wr_en64, done64;
    int          wcnt64, oerr64;

    logic [4:0]  rd_addr32, wr_addr32;
    logic [31:0] rd_data32, wr_data32;
    logic        wr_en32, done32;
    int          wcnt32, oerr32;

    int n_checks = 0;
    int n_fail = 0;
    bit wd_fired = 1'b0;

    always #4 clk = ~clk;

    relu_stream_engine #(.DATA_W(32), .VEC_LEN(N64)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start64),
        .rd_addr_o(rd_addr64), .rd_data_i(rd_data64),
        .wr_addr_o(wr_addr64), .wr_data_o(wr_data64),
        .wr_en_o(wr_en64), .done_o(done64));

    relu_ram_model #(.DEPTH(N64), .AW(6)) u_ram64 (
        .clk(clk), .clr(clr), .rd_addr(rd_addr64), .rd_data(rd_data64),
        .wr_addr(wr_addr64), .wr_data(wr_data64), .wr_en(wr_en64),
        .wr_count(wcnt64), .order_err(oerr64));

    relu_stream_engine #(.DATA_W(32), .VEC_LEN(N32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .start_i(start32),
        .rd_addr_o(rd_addr32), .rd_data_i(rd_data32),
        .wr_addr_o(wr_addr32), .wr_data_o(wr_data32),
        .wr_en_o(wr_en32), .done_o(done32));

    relu_ram_model #(.DEPTH(N32), .AW(5)) u_ram32 (
        .clk(clk), .clr(clr), .rd_addr(rd_addr32), .rd_data(rd_data32),
        .wr_addr(wr_addr32), .wr_data(wr_data32), .wr_en(wr_en32),
        .wr_count(wcnt32), .order_err(oerr32));

    function automatic logic [31:0] ref_clamp(input logic [31:0] v);
        return v[31] ? 32'd0 : v;
    endfunction

    function automatic logic [31:0] pattern_word(input int pat, input int i);
        case (pat)
            0: case (i % 4)
                   0: return 32'(i * 37);
                   1: return 32'(-(i * 11 + 1));
                   2: return 32'd0;
                   default: return (i % 8 == 3) ? 32'h8000_0000 : 32'h7FFF_FFFF;
               endcase
            1: return 32'(-(i + 1));
            2: return (i == 0) ? 32'h7FFF_FFFF : 32'(i + 1);
            default: return (i % 2 == 0) ? 32'hFFFF_FFFF : 32'd1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_rams();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic fill64(input int pat);
        for (int i = 0; i < N64; i++) u_ram64.src[i] = pattern_word(pat, i);
    endtask

    // one pass on the 64-element engine; optional start while busy at cycle busy_at
    task automatic run64(input int pat, input int busy_at, input string tag);
        int cyc;
        int bad;
        fill64(pat);
        clear_rams();
        @(negedge clk); start64 = 1'b1;
        @(negedge clk); start64 = 1'b0;
        cyc = 0;
        while (!done64 && cyc < 4 * N64 + 20) begin
            if (cyc == busy_at) start64 = 1'b1;
            if (cyc == busy_at + 1) start64 = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start64 = 1'b0;
        // R7 (and R3 two cycles per element, R9 timing unchanged by busy start)
        check(cyc == 2 * N64, {"R7 pass length ", tag}, cyc, 2 * N64);
        // R5 / R3 / R9 write count and order
        check(wcnt64 == N64, {"R5 write count ", tag}, wcnt64, N64);
        check(oerr64 == 0, {"R3 R5 order/hold ", tag}, oerr64, 0);
        bad = 0;
        for (int i = 0; i < N64; i++) begin
            if (u_ram64.dst[i] !== ref_clamp(pattern_word(pat, i))) begin
                if (bad == 0)
                    check(1'b0, {"R4 data ", tag}, u_ram64.dst[i], ref_clamp(pattern_word(pat, i)));
                bad++;
            end
        end
        if (bad == 0) check(1'b1, {"R4 data ", tag}, 0, 0);
    endtask

    task automatic t_reset();
        // R1
        check(done64 == 1'b0, "R1 done after reset", done64, 0);
        check(wr_en64 == 1'b0, "R1 wr_en after reset", wr_en64, 0);
        // R6 idle: no strobe over several idle cycles
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(wr_en64 == 1'b0 && done64 == 1'b0, "R6 idle wr_en", wr_en64, 0);
        end
    endtask

    task automatic t_first_read();
        fill64(0);
        @(negedge clk); start64 = 1'b1;
        @(negedge clk); start64 = 1'b0;
        // R2: first address is 0, no write yet (wait cycle, R3)
        check(rd_addr64 == 6'd0, "R2 first read address", rd_addr64, 0);
        check(wr_en64 == 1'b0, "R3 wait before first write", wr_en64, 0);
        @(negedge clk);
        check(wr_en64 == 1'b1 && wr_addr64 == 6'd0, "R3 first strobe", wr_addr64, 0);
        @(negedge clk);
        check(wr_en64 == 1'b0 && rd_addr64 == 6'd1, "R5 next address", rd_addr64, 1);
        while (!done64) @(negedge clk);
    endtask

    task automatic t_finish_hold_and_restart();
        // R8 / R6: done held, no strobes in finish
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(done64 == 1'b1, "R8 done held", done64, 1);
            check(wr_en64 == 1'b0, "R6 finish wr_en", wr_en64, 0);
        end
        @(negedge clk); start64 = 1'b1;
        @(negedge clk); start64 = 1'b0;
        check(done64 == 1'b0, "R8 done cleared by start", done64, 0);
        check(rd_addr64 == 6'd0, "R8 restart from index 0", rd_addr64, 0);
        while (!done64) @(negedge clk);
    endtask

    task automatic t_len32();
        int cyc;
        int bad;
        for (int i = 0; i < N32; i++) u_ram32.src[i] = pattern_word(0, i);
        clear_rams();
        @(negedge clk); start32 = 1'b1;
        @(negedge clk); start32 = 1'b0;
        cyc = 0;
        while (!done32 && cyc < 4 * N32 + 20) begin
            @(negedge clk);
            cyc++;
        end
        // R10
        check(cyc == 2 * N32, "R10 pass length at 32", cyc, 2 * N32);
        check(wcnt32 == N32 && oerr32 == 0, "R10 writes at 32", wcnt32, N32);
        bad = 0;
        for (int i = 0; i < N32; i++)
            if (u_ram32.dst[i] !== ref_clamp(pattern_word(0, i))) bad++;
        check(bad == 0, "R10 data at 32", bad, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_read();
        run64(0, -10, "mixed");
        t_finish_hold_and_restart();
        run64(1, -10, "negative");
        run64(2, -10, "positive");
        run64(3, -10, "alternating");
        // R9: start mid-pass ignored
        run64(0, 7, "busy start");
        t_len32();
    endtask

    initial begin
        fork
            run_all();
            begin
                #(8 * 150000);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule